// File: doc/BRIEF.md
# Charging-Current Measurement Front End

This block runs the measurement side of a capacitor-module charger. Each time `sample_start` pulses, it drives an SPI master through two conversion frames on a two-channel, 12-bit ADC. The first frame reads the current-sense channel. The second reads the module-voltage channel.

The current-sense input sits at mid-rail when no current flows. The block removes that offset and rescales the code into a signed charging current in units of 10 mA. With a 0.0025 Ω shunt, a gain of 25 and a 5 V span, each code step is worth 1.953125 units. The voltage code is not scaled and is handed on as is, for state-of-charge estimation. Once both frames are finished, the two results appear together with a one-cycle valid pulse, which the regulator uses as its sample.

The SPI clock is the system clock divided by a parameter. Every frame is a single chip-select-low transaction. The command bits go out most significant first, and the reply is sampled on the rising SCLK edge.

Top module: `chg_meas_scaler`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `meas_valid` is 0, and `meas_current` and `meas_volt_code` are 0.
- R2: An accepted start produces exactly two frames, in a fixed order. The first frame is the current channel, with command 4'b1101. The second is the voltage channel, with command 4'b1111. Bit 1 of the command selects the channel, and the command goes out MSB first on `spi_mosi`. `spi_mosi` changes only while SCLK is low.
- R3: Each frame keeps `spi_cs_n` low for exactly 17 rising SCLK edges: 4 command bits, 1 null bit and 12 data bits. Every SCLK high phase lasts DIV_HALF system clocks (default 4). SCLK stays low whenever chip select is high.
- R4: The ADC code is taken from the last 12 bits sampled on `spi_miso`, MSB first.
- R5: `meas_current` is the current code c converted as floor((c − 2048) × 125 / 64 + 0.5), as a signed value in units of 10 mA. A code of 2048 reads 0, and a code of 2597 reads 1072.
- R6: The full code range maps within ±4000: code 0 reads −4000 and code 4095 reads 3998. Any result beyond ±LIMIT is clamped to LIMIT.
- R7: `meas_volt_code` equals the raw voltage-channel code, unchanged.
- R8: `meas_valid` is high for exactly one clock once the voltage frame has finished. Both results stay stable until the next valid pulse.
- R9: A `sample_start` that arrives while a sample is in progress is ignored. It causes no extra frame and no extra valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_start | input | 1 | One-cycle request to take a current/voltage sample pair |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | ADC chip select, active low |
| spi_mosi | output | 1 | Command bits to the ADC |
| spi_miso | input | 1 | Conversion bits from the ADC |
| meas_valid | output | 1 | One-cycle strobe marking new results |
| meas_current | output | 16 | Signed charging current, 10 mA units |
| meas_volt_code | output | 12 | Raw module-voltage code |

## Verification
The current-channel codes are chosen to separate the possible errors:
- Mid-rail (2048) exposes an offset error.
- The codes one step either side of mid-rail separate rounding from truncation in both signs.
- The pair 3584/512 gives exact ±3000 readings and so checks the scale factor.
- The rail codes 0 and 4095 cover the range ends.
- The known 1072 point checks a fractional product.

The voltage codes use alternating bit patterns, so that a bit-order or channel swap shows up as a wrong value. A separate scenario fires repeated starts during both frames to confirm they are ignored.

// File: rtl/meas_pkg.sv
package meas_pkg;

   // channel select values placed in command bit 1
   localparam logic CH_CURRENT = 1'b0;
   localparam logic CH_VOLTAGE = 1'b1;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_SHIFT = 2'd1,
      ENG_FIN   = 2'd2
   } eng_state_t;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_CUR  = 2'd1,
      SEQ_VOLT = 2'd2
   } seq_state_t;

endpackage

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import meas_pkg::*;
#(
   parameter int CMD_W    = 4,
   parameter int GAP_W    = 1,
   parameter int DATA_W   = 12,
   parameter int DIV_HALF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CMD_W-1:0]  cmd,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_code,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);

   localparam int FRAME_LEN = CMD_W + GAP_W + DATA_W;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);
   localparam int DIV_W     = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   if (DIV_HALF < 1) begin : g_bad_div
      $error("spi_frame_engine: DIV_HALF must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("spi_frame_engine: DATA_W must be at least 2");
   end

   eng_state_t        state;
   logic [DIV_W-1:0]  div_cnt;
   logic [CNT_W-1:0]  bit_cnt;
   logic [CMD_W-1:0]  tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic              half_tick;

   assign half_tick = (div_cnt == DIV_W'(DIV_HALF - 1));
   assign busy      = (state != ENG_IDLE);
   assign rx_code   = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ENG_IDLE;
         div_cnt <= '0;
         bit_cnt <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         sclk    <= 1'b0;
         cs_n    <= 1'b1;
         mosi    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ENG_IDLE: begin
               if (go) begin
                  cs_n    <= 1'b0;
                  mosi    <= cmd[CMD_W-1];
                  tx_sh   <= cmd << 1;
                  div_cnt <= '0;
                  bit_cnt <= '0;
                  state   <= ENG_SHIFT;
               end
            end
            ENG_SHIFT: begin
               if (half_tick) begin
                  div_cnt <= '0;
                  if (!sclk) begin
                     sclk    <= 1'b1;
                     rx_sh   <= {rx_sh[DATA_W-2:0], miso};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (bit_cnt == CNT_W'(FRAME_LEN)) begin
                        state <= ENG_FIN;
                     end else begin
                        mosi  <= tx_sh[CMD_W-1];
                        tx_sh <= tx_sh << 1;
                     end
                  end
               end else begin
                  div_cnt <= div_cnt + 1'b1;
               end
            end
            ENG_FIN: begin
               cs_n  <= 1'b1;
               mosi  <= 1'b0;
               done  <= 1'b1;
               state <= ENG_IDLE;
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   AST_SCLK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk); // R3
   AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n); // R3
   AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sclk) |-> $stable(mosi)); // R2
   AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (state == ENG_IDLE)); // R9

endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer
   import meas_pkg::*;
#(
   parameter int CMD_W  = 4,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rx,
   output logic              eng_go,
   output logic [CMD_W-1:0]  eng_cmd,
   output logic [DATA_W-1:0] cur_code,
   output logic [DATA_W-1:0] volt_code,
   output logic              pair_rdy
);

   // start, single-ended, channel, MSB-first flag; leading zeros if wider
   localparam logic [CMD_W-1:0] CMD_BASE = CMD_W'(4'b1101);

   if (CMD_W < 4) begin : g_bad_cmd
      $error("meas_sequencer: CMD_W must be at least 4");
   end

   seq_state_t state;

   function automatic logic [CMD_W-1:0] cmd_for(input logic ch);
      return CMD_BASE | (CMD_W'(ch) << 1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         eng_go    <= 1'b0;
         eng_cmd   <= '0;
         cur_code  <= '0;
         volt_code <= '0;
         pair_rdy  <= 1'b0;
      end else begin
         eng_go   <= 1'b0;
         pair_rdy <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  eng_go  <= 1'b1;
                  eng_cmd <= cmd_for(CH_CURRENT);
                  state   <= SEQ_CUR;
               end
            end
            SEQ_CUR: begin
               if (eng_done) begin
                  cur_code <= eng_rx;
                  eng_go   <= 1'b1;
                  eng_cmd  <= cmd_for(CH_VOLTAGE);
                  state    <= SEQ_VOLT;
               end
            end
            SEQ_VOLT: begin
               if (eng_done) begin
                  volt_code <= eng_rx;
                  pair_rdy  <= 1'b1;
                  state     <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   AST_VOLT_FOLLOWS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_go && eng_cmd[1]) |-> $past(eng_done)); // R2

endmodule

// File: rtl/current_scaler.sv
module current_scaler #(
   parameter int DATA_W      = 12,
   parameter int OUT_W       = 16,
   parameter int SCALE_NUM   = 125,
   parameter int SCALE_SHIFT = 6,
   parameter int LIMIT       = 4000,
   parameter bit ROUND_EN    = 1'b1
) (
   input  logic [DATA_W-1:0]        code,
   output logic signed [OUT_W-1:0]  amps
);

   localparam int MID    = 1 << (DATA_W - 1);
   localparam int PROD_W = DATA_W + 2 + $clog2(SCALE_NUM + 1);

   if (OUT_W > PROD_W || OUT_W < 2) begin : g_bad_out
      $error("current_scaler: OUT_W out of range");
   end
   if (SCALE_SHIFT < 1) begin : g_bad_shift
      $error("current_scaler: SCALE_SHIFT must be at least 1");
   end

   logic signed [PROD_W-1:0] diff_s;
   logic signed [PROD_W-1:0] prod_s;
   logic signed [PROD_W-1:0] adj_s;
   logic signed [PROD_W-1:0] sh_s;

   assign diff_s = $signed({{(PROD_W-DATA_W){1'b0}}, code}) - $signed(PROD_W'(MID));
   assign prod_s = diff_s * $signed(PROD_W'(SCALE_NUM));

   if (ROUND_EN) begin : g_round
      assign adj_s = prod_s + $signed(PROD_W'(1 << (SCALE_SHIFT - 1)));
   end else begin : g_trunc
      assign adj_s = prod_s;
   end

   assign sh_s = adj_s >>> SCALE_SHIFT;

   always_comb begin
      if (sh_s > $signed(PROD_W'(LIMIT)))
         amps = OUT_W'(LIMIT);
      else if (sh_s < -$signed(PROD_W'(LIMIT)))
         amps = -$signed(OUT_W'(LIMIT));
      else
         amps = sh_s[OUT_W-1:0];
   end

endmodule

// File: rtl/chg_meas_scaler.sv
module chg_meas_scaler
   import meas_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int CMD_W       = 4,
   parameter int GAP_W       = 1,
   parameter int DIV_HALF    = 4,
   parameter int OUT_W       = 16,
   parameter int SCALE_NUM   = 125,
   parameter int SCALE_SHIFT = 6,
   parameter int LIMIT       = 4000,
   parameter bit ROUND_EN    = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sample_start,
   output logic                     spi_sclk,
   output logic                     spi_cs_n,
   output logic                     spi_mosi,
   input  logic                     spi_miso,
   output logic                     meas_valid,
   output logic signed [OUT_W-1:0]  meas_current,
   output logic [DATA_W-1:0]        meas_volt_code
);

   logic              eng_go, eng_done, eng_busy;
   logic [CMD_W-1:0]  eng_cmd;
   logic [DATA_W-1:0] eng_rx, cur_code, volt_code;
   logic              pair_rdy;
   logic signed [OUT_W-1:0] scaled;

   meas_sequencer #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(sample_start),
      .eng_done(eng_done), .eng_rx(eng_rx),
      .eng_go(eng_go), .eng_cmd(eng_cmd),
      .cur_code(cur_code), .volt_code(volt_code), .pair_rdy(pair_rdy)
   );

   spi_frame_engine #(.CMD_W(CMD_W), .GAP_W(GAP_W), .DATA_W(DATA_W),
                      .DIV_HALF(DIV_HALF)) u_eng (
      .clk(clk), .rst_n(rst_n), .go(eng_go), .cmd(eng_cmd),
      .busy(eng_busy), .done(eng_done), .rx_code(eng_rx),
      .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
   );

   current_scaler #(.DATA_W(DATA_W), .OUT_W(OUT_W), .SCALE_NUM(SCALE_NUM),
                    .SCALE_SHIFT(SCALE_SHIFT), .LIMIT(LIMIT),
                    .ROUND_EN(ROUND_EN)) u_scale (
      .code(cur_code), .amps(scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_valid     <= 1'b0;
         meas_current   <= '0;
         meas_volt_code <= '0;
      end else begin
         meas_valid <= pair_rdy;
         if (pair_rdy) begin
            meas_current   <= scaled;
            meas_volt_code <= volt_code;
         end
      end
   end

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> !meas_valid); // R8
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> $stable(meas_volt_code)); // R7
   AST_CURRENT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (meas_current <= $signed(OUT_W'(LIMIT)) &&
                      meas_current >= -$signed(OUT_W'(LIMIT)))); // R6
   AST_NO_FRAME_WHILE_SEQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_rdy |-> !eng_busy); // R9

endmodule

// File: tb/chg_meas_scaler_test.sv
`timescale 1ns/1ps
module chg_meas_scaler_test;

   localparam int DIV_HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_start = 1'b0;
   logic spi_sclk, spi_cs_n, spi_mosi;
   logic spi_miso;
   logic meas_valid;
   logic signed [15:0] meas_current;
   logic [11:0] meas_volt_code;

   always #2.5 clk = ~clk;

   chg_meas_scaler #(.DIV_HALF(DIV_HALF)) uut (
      .clk(clk), .rst_n(rst_n), .sample_start(sample_start),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .meas_valid(meas_valid),
      .meas_current(meas_current), .meas_volt_code(meas_volt_code)
   );

   int tests = 0;
   int fails = 0;

   // ---------------- ADC model ----------------
   logic [11:0] code_i = 12'd0;
   logic [11:0] code_v = 12'd0;
   logic        in_frame = 1'b0;
   int          idx = 0;
   int          pcnt = 0;
   int          frames = 0;
   logic [3:0]  cmd_sh = 4'd0;
   logic [3:0]  cmd_log [8];
   int          bit_log [8];

   always @(negedge spi_cs_n or posedge spi_cs_n or negedge spi_sclk or posedge spi_sclk) begin
      if (spi_cs_n === 1'b1) begin
         if (in_frame) begin
            cmd_log[frames % 8] = cmd_sh;
            bit_log[frames % 8] = pcnt;
            frames++;
         end
         in_frame = 1'b0;
      end else if (spi_cs_n === 1'b0 && !in_frame) begin
         in_frame = 1'b1;
         idx = 0;
         pcnt = 0;
         cmd_sh = 4'd0;
      end else if (spi_sclk === 1'b1) begin
         if (pcnt < 4) cmd_sh = {cmd_sh[2:0], spi_mosi};
         pcnt++;
      end else begin
         idx++;
      end
   end

   always @* begin
      logic [11:0] word;
      word = cmd_sh[1] ? code_v : code_i;
      if (in_frame && idx >= 5 && idx < 17) spi_miso = word[11 - (idx - 5)];
      else spi_miso = 1'b0;
   end

   // ---------------- monitors ----------------
   int vcount = 0;
   int hi_run = 0;
   int hi_min = 1000;
   int hi_max = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (meas_valid) vcount++;
         if (spi_sclk) hi_run++;
         else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_cur(int c);
      real x;
      int  r;
      x = (c - 2048) * 1.953125 + 0.5;
      r = $rtoi($floor(x));
      if (r > 4000) r = 4000;
      if (r < -4000) r = -4000;
      return r;
   endfunction

   task automatic pulse_start();
      @(negedge clk) sample_start = 1'b1;
      @(negedge clk) sample_start = 1'b0;
   endtask

   task automatic wait_valid(output bit got);
      got = 1'b0;
      for (int k = 0; k < 3000 && !got; k++) begin
         @(negedge clk);
         if (meas_valid) got = 1'b1;
      end
   endtask

   task automatic run_sample(int ic, int vc, string req);
      int f0;
      bit got;
      f0 = frames;
      code_i = 12'(ic);
      code_v = 12'(vc);
      pulse_start();
      wait_valid(got);
      chk("R8 valid seen", int'(got), 1);
      chk(req, int'(meas_current), exp_cur(ic));
      chk("R7 voltage code", int'(meas_volt_code), vc);
      chk("R2 frame count", frames - f0, 2);
      chk("R2 first command", int'(cmd_log[f0 % 8]), 13);
      chk("R2 second command", int'(cmd_log[(f0 + 1) % 8]), 15);
      chk("R3 edges per frame", bit_log[f0 % 8], 17);
      @(negedge clk);
      chk("R8 valid one cycle", int'(meas_valid), 0);
   endtask

   task automatic t_reset();
      chk("R1 cs_n", int'(spi_cs_n), 1);
      chk("R1 sclk", int'(spi_sclk), 0);
      chk("R1 valid", int'(meas_valid), 0);
      chk("R1 current", int'(meas_current), 0);
      chk("R1 volt", int'(meas_volt_code), 0);
   endtask

   task automatic t_hold();
      int c0, v0;
      c0 = int'(meas_current);
      v0 = int'(meas_volt_code);
      repeat (100) @(negedge clk);
      chk("R8 current held", int'(meas_current), c0);
      chk("R8 volt held", int'(meas_volt_code), v0);
   endtask

   task automatic t_busy_ignore();
      int f0, v0;
      bit got;
      f0 = frames;
      v0 = vcount;
      code_i = 12'd3000;
      code_v = 12'd1234;
      pulse_start();
      repeat (40) @(negedge clk);
      pulse_start();
      repeat (150) @(negedge clk);
      pulse_start();
      wait_valid(got);
      repeat (400) @(negedge clk);
      chk("R9 frames", frames - f0, 2);
      chk("R9 valid pulses", vcount - v0, 1);
      chk("R9 current", int'(meas_current), exp_cur(3000));
      chk("R9 cs idle", int'(spi_cs_n), 1);
   endtask

   // ---------------- main ----------------
   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      run_sample(2048, 12'hA5A, "R5 mid-rail zero");
      run_sample(2597, 12'h5A5, "R5 known point 1072");
      run_sample(3584, 12'hFFF, "R5 plus 30 A");
      run_sample(512,  12'h000, "R5 minus 30 A");
      run_sample(2049, 12'h801, "R5 one step up");
      run_sample(2047, 12'h7FE, "R5 one step down");
      run_sample(0,    12'h3C3, "R6 negative rail");
      run_sample(4095, 12'hC3C, "R6 positive rail");
      run_sample(12'hA5A, 12'h001, "R4 bit order");
      t_hold();
      t_busy_ignore();
      chk("R3 sclk high min", hi_min, DIV_HALF);
      chk("R3 sclk high max", hi_max, DIV_HALF);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #500000;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule